// File: doc/BRIEF.md
# Banked Auxiliary Control Register Access Unit

This block holds one 32-bit auxiliary control register in two copies: a primary copy (bank 0) and a non-secure copy (bank 1). It decodes coprocessor-style move-to-register and move-from-register requests. A request is first checked against the current privilege level and then against the trap enables set by the hypervisor. The block then does one of three things:

- it reads or writes one copy;
- it reports an undefined instruction;
- it reports a trap to the hypervisor, together with a syndrome code.

All 32 bits are stored as opaque data. The outcome is combinational and valid in the same cycle as the request strobe. A write lands on the next rising clock edge.

The surrounding pipeline uses the outcome to retire the instruction, to raise an undefined-instruction exception, or to route a trap. When the block does not claim a request, its outcome outputs stay quiet.

Top module: `sysreg_bank_ctl`

## Requirements
- R1: A request is claimed (`claimed`=1) only when reqValid=1 and the encoding is coprocessor 15, op1=0, CRn=1, CRm=0, op2=1. An unclaimed request drives every outcome output low, returns rdData=0 and changes no copy.
- R2: For a claimed request, exactly one of outOk, outUndef, outTrap64, outTrap32 is 1, in the same cycle as the strobe.
- R3: A claimed request with curLevel=0 (curLevel carries the level number 0..3) gives outUndef, for both reads and writes.
- R4: At curLevel=1 with hypEnabled=1, the following are checked in this order and the first hit wins. With hypIs64=1: grpTrap64, then auxTrap64, and a hit gives outTrap64. With hypIs64=0: grpTrap32, then auxTrap32, and a hit gives outTrap32. Trap bits belonging to the other execution state are ignored. With hypEnabled=0, or at any other level, no trap is raised.
- R5: syndrome is 8'h03 whenever a trap is reported, and 8'h00 otherwise.
- R6: At curLevel 1 or 2 with no trap, the access uses bank 1 when monPresent=1 and monIs64=0, and bank 0 otherwise.
- R7: At curLevel=3 the access uses bank 0 when nsBit=0 and bank 1 when nsBit=1.
- R8: A read with outOk returns the selected copy on rdData. Any undefined or trapped read returns rdData=0.
- R9: A write with outOk updates only the selected copy, on the next rising edge. A trapped or undefined write changes no copy.
- R10: A synchronous active-low reset clears both copies to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| reqValid | input | 1 | Request strobe |
| reqWrite | input | 1 | 1 = move to register (write), 0 = read |
| reqCp | input | 4 | Coprocessor number |
| reqOp1 | input | 3 | First opcode field |
| reqCrn | input | 4 | Primary register field |
| reqCrm | input | 4 | Secondary register field |
| reqOp2 | input | 3 | Second opcode field |
| wrData | input | 32 | Write data |
| curLevel | input | 2 | Current privilege level |
| hypEnabled | input | 1 | Hypervisor level enabled |
| hypIs64 | input | 1 | Hypervisor runs in 64-bit state |
| monPresent | input | 1 | Monitor level implemented |
| monIs64 | input | 1 | Monitor runs in 64-bit state |
| nsBit | input | 1 | Non-secure bit of the secure configuration |
| grpTrap64 | input | 1 | Group-1 coprocessor trap, 64-bit hypervisor control |
| grpTrap32 | input | 1 | Group-1 coprocessor trap, 32-bit hypervisor control |
| auxTrap64 | input | 1 | Auxiliary-control trap, 64-bit hypervisor control |
| auxTrap32 | input | 1 | Auxiliary-control trap, 32-bit hypervisor control |
| claimed | output | 1 | Request decoded by this block |
| outOk | output | 1 | Access performed |
| outUndef | output | 1 | Undefined instruction |
| outTrap64 | output | 1 | Trap to 64-bit hypervisor |
| outTrap32 | output | 1 | Trap to 32-bit hypervisor |
| syndrome | output | 8 | Trap syndrome class |
| rdData | output | 32 | Read data |

## Verification
A wrong copy or a write landing in the wrong bank stays hidden until a later read selects that bank. Level-3 reads with each value of nsBit are therefore mixed into the random stream, so a corrupted bank shows on rdData at the next such read, a few cycles later. Errors in the trap priority or the bank selection show at once on the one-hot outcome and on rdData of the same request. A write that leaks through a trap or an undefined outcome appears on the first later read of that copy.

// File: rtl/sysreg_bank_pkg.sv
package sysreg_bank_pkg;
  localparam int DATA_W = 32;
  localparam int SYN_W = 8;
  localparam int NUM_BANKS = 2;
  localparam int BANK_W = $clog2(NUM_BANKS);

  localparam logic [SYN_W-1:0] TRAP_CLASS = 8'h03;

  typedef struct packed {
    logic rdEn;
    logic wrEn;
    logic [BANK_W-1:0] bankSel;
  } bank_ctl_t;
endpackage

// File: rtl/sysreg_bank_ctrl.sv
module sysreg_bank_ctrl
  import sysreg_bank_pkg::*;
#(
  parameter logic [3:0] MATCH_CP = 4'd15,
  parameter logic [2:0] MATCH_OP1 = 3'd0,
  parameter logic [3:0] MATCH_CRN = 4'd1,
  parameter logic [3:0] MATCH_CRM = 4'd0,
  parameter logic [2:0] MATCH_OP2 = 3'd1
) (
  input  logic reqValid,
  input  logic reqWrite,
  input  logic [3:0] reqCp,
  input  logic [2:0] reqOp1,
  input  logic [3:0] reqCrn,
  input  logic [3:0] reqCrm,
  input  logic [2:0] reqOp2,
  input  logic [1:0] curLevel,
  input  logic hypEnabled,
  input  logic hypIs64,
  input  logic monPresent,
  input  logic monIs64,
  input  logic nsBit,
  input  logic grpTrap64,
  input  logic grpTrap32,
  input  logic auxTrap64,
  input  logic auxTrap32,
  output logic claimed,
  output logic outOk,
  output logic outUndef,
  output logic outTrap64,
  output logic outTrap32,
  output logic [SYN_W-1:0] syndrome,
  output bank_ctl_t ctl
);
  logic encHit;
  logic atLevel0, atLevel1, atLevel2, atLevel3;
  logic trapHit;
  logic trapTo64;
  logic [BANK_W-1:0] sel;

  assign encHit = (reqCp == MATCH_CP) && (reqOp1 == MATCH_OP1) &&
                  (reqCrn == MATCH_CRN) && (reqCrm == MATCH_CRM) &&
                  (reqOp2 == MATCH_OP2);
  assign claimed = reqValid && encHit;

  assign atLevel0 = (curLevel == 2'd0);
  assign atLevel1 = (curLevel == 2'd1);
  assign atLevel2 = (curLevel == 2'd2);
  assign atLevel3 = (curLevel == 2'd3);

  // Fixed-priority trap chain, evaluated only at level 1.
  always_comb begin
    trapHit = 1'b0;
    trapTo64 = 1'b0;
    if (atLevel1 && hypEnabled) begin
      if (hypIs64 && grpTrap64) begin
        trapHit = 1'b1;
        trapTo64 = 1'b1;
      end else if (!hypIs64 && grpTrap32) begin
        trapHit = 1'b1;
      end else if (hypIs64 && auxTrap64) begin
        trapHit = 1'b1;
        trapTo64 = 1'b1;
      end else if (!hypIs64 && auxTrap32) begin
        trapHit = 1'b1;
      end
    end
  end

  // Bank choice: level 3 follows nsBit; levels 1 and 2 follow the monitor state.
  always_comb begin
    sel = '0;
    if (atLevel3) sel = BANK_W'(nsBit);
    else if (atLevel1 || atLevel2) sel = BANK_W'(monPresent && !monIs64);
  end

  assign outUndef = claimed && atLevel0;
  assign outTrap64 = claimed && trapHit && trapTo64;
  assign outTrap32 = claimed && trapHit && !trapTo64;
  assign outOk = claimed && !atLevel0 && !trapHit;
  assign syndrome = (outTrap64 || outTrap32) ? TRAP_CLASS : '0;

  assign ctl.rdEn = outOk && !reqWrite;
  assign ctl.wrEn = outOk && reqWrite;
  assign ctl.bankSel = sel;
endmodule

// File: rtl/sysreg_bank_data.sv
module sysreg_bank_data
  import sysreg_bank_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  bank_ctl_t ctl,
  input  logic [DATA_W-1:0] wrData,
  output logic [NUM_BANKS-1:0][DATA_W-1:0] bankQ,
  output logic [DATA_W-1:0] rdData
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rstN) bankQ[b] <= '0;
      else if (ctl.wrEn && (ctl.bankSel == BANK_W'(b))) bankQ[b] <= wrData;
    end
  end

  assign rdData = ctl.rdEn ? bankQ[ctl.bankSel] : '0;
endmodule

// File: rtl/sysreg_bank_ctl.sv
module sysreg_bank_ctl
  import sysreg_bank_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic reqValid,
  input  logic reqWrite,
  input  logic [3:0] reqCp,
  input  logic [2:0] reqOp1,
  input  logic [3:0] reqCrn,
  input  logic [3:0] reqCrm,
  input  logic [2:0] reqOp2,
  input  logic [31:0] wrData,
  input  logic [1:0] curLevel,
  input  logic hypEnabled,
  input  logic hypIs64,
  input  logic monPresent,
  input  logic monIs64,
  input  logic nsBit,
  input  logic grpTrap64,
  input  logic grpTrap32,
  input  logic auxTrap64,
  input  logic auxTrap32,
  output logic claimed,
  output logic outOk,
  output logic outUndef,
  output logic outTrap64,
  output logic outTrap32,
  output logic [7:0] syndrome,
  output logic [31:0] rdData
);
  bank_ctl_t ctl;
  logic [NUM_BANKS-1:0][DATA_W-1:0] bankQ;

  sysreg_bank_ctrl u_ctrl (
    .reqValid(reqValid), .reqWrite(reqWrite), .reqCp(reqCp), .reqOp1(reqOp1),
    .reqCrn(reqCrn), .reqCrm(reqCrm), .reqOp2(reqOp2), .curLevel(curLevel),
    .hypEnabled(hypEnabled), .hypIs64(hypIs64), .monPresent(monPresent),
    .monIs64(monIs64), .nsBit(nsBit), .grpTrap64(grpTrap64),
    .grpTrap32(grpTrap32), .auxTrap64(auxTrap64), .auxTrap32(auxTrap32),
    .claimed(claimed), .outOk(outOk), .outUndef(outUndef),
    .outTrap64(outTrap64), .outTrap32(outTrap32), .syndrome(syndrome),
    .ctl(ctl)
  );

  sysreg_bank_data u_data (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrData(wrData),
    .bankQ(bankQ), .rdData(rdData)
  );
endmodule

// File: rtl/sysreg_bank_chk.sv
module sysreg_bank_chk (
  input logic clk,
  input logic rstN,
  input logic reqValid,
  input logic reqWrite,
  input logic [1:0] curLevel,
  input logic claimed,
  input logic outOk,
  input logic outUndef,
  input logic outTrap64,
  input logic outTrap32,
  input logic [7:0] syndrome,
  input logic [31:0] rdData,
  input logic [1:0][31:0] bankQ
);
  a_r1_quiet_unclaimed: assert property (@(posedge clk) disable iff (!rstN)
    !claimed |-> !(outOk || outUndef || outTrap64 || outTrap32) && rdData == '0);

  a_r2_one_outcome: assert property (@(posedge clk) disable iff (!rstN)
    claimed |-> $countones({outOk, outUndef, outTrap64, outTrap32}) == 1);

  a_r3_level0_undef: assert property (@(posedge clk) disable iff (!rstN)
    claimed && curLevel == 2'd0 |-> outUndef);

  a_r4_trap_level1_only: assert property (@(posedge clk) disable iff (!rstN)
    (outTrap64 || outTrap32) |-> curLevel == 2'd1);

  a_r5_trap_syndrome: assert property (@(posedge clk) disable iff (!rstN)
    (outTrap64 || outTrap32) |-> syndrome == 8'h03);

  a_r5_quiet_syndrome: assert property (@(posedge clk) disable iff (!rstN)
    !(outTrap64 || outTrap32) |-> syndrome == 8'h00);

  a_r8_failed_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    !outOk |-> rdData == '0);

  a_r9_no_stray_write: assert property (@(posedge clk) disable iff (!rstN)
    !(outOk && reqWrite) |=> $stable(bankQ));
endmodule

bind sysreg_bank_ctl sysreg_bank_chk u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
  .curLevel(curLevel), .claimed(claimed), .outOk(outOk), .outUndef(outUndef),
  .outTrap64(outTrap64), .outTrap32(outTrap32), .syndrome(syndrome),
  .rdData(rdData), .bankQ(bankQ)
);

// File: tb/sim_sysreg_bank_ctl.sv
module sim_sysreg_bank_ctl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqWrite = 1'b0;
  logic [3:0] reqCp = '0;
  logic [2:0] reqOp1 = '0;
  logic [3:0] reqCrn = '0;
  logic [3:0] reqCrm = '0;
  logic [2:0] reqOp2 = '0;
  logic [31:0] wrData = '0;
  logic [1:0] curLevel = '0;
  logic hypEnabled = 0, hypIs64 = 0, monPresent = 0, monIs64 = 0, nsBit = 0;
  logic grpTrap64 = 0, grpTrap32 = 0, auxTrap64 = 0, auxTrap32 = 0;
  logic claimed, outOk, outUndef, outTrap64, outTrap32;
  logic [7:0] syndrome;
  logic [31:0] rdData;

  int nChecks = 0;
  int nFails = 0;
  logic [31:0] mdl [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  sysreg_bank_ctl u0 (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Outcome code: 0 none, 1 ok, 2 undef, 3 trap64, 4 trap32.
  function automatic int expOutcome();
    if (!(reqValid && reqCp == 4'd15 && reqOp1 == 3'd0 && reqCrn == 4'd1 &&
          reqCrm == 4'd0 && reqOp2 == 3'd1)) return 0;
    if (curLevel == 2'd0) return 2;
    if (curLevel == 2'd1 && hypEnabled) begin
      if (hypIs64 && (grpTrap64 || auxTrap64)) return 3;
      if (!hypIs64 && (grpTrap32 || auxTrap32)) return 4;
    end
    return 1;
  endfunction

  function automatic int expBank();
    if (curLevel == 2'd3) return int'(nsBit);
    return (monPresent && !monIs64) ? 1 : 0;
  endfunction

  task automatic setEnc(input logic good);
    if (good) begin
      reqCp = 4'd15; reqOp1 = 3'd0; reqCrn = 4'd1; reqCrm = 4'd0; reqOp2 = 3'd1;
    end else begin
      reqCp = 4'd15; reqOp1 = 3'd0; reqCrn = 4'd1; reqCrm = 4'd0; reqOp2 = 3'd1;
      case ($urandom_range(4, 0))
        0: reqCp = 4'd14;
        1: reqOp1 = 3'd1;
        2: reqCrn = 4'd0;
        3: reqCrm = 4'd1;
        default: reqOp2 = 3'd0;
      endcase
    end
  endtask

  // Drive at negedge; sample a quarter period later; commit model at posedge.
  task automatic doReq(input string req);
    int oc;
    int bk;
    #(CLK_PERIOD/4);
    oc = expOutcome();
    bk = expBank();
    check({req, " R2 outcome"}, {claimed, outOk, outUndef, outTrap64, outTrap32},
          {oc != 0, oc == 1, oc == 2, oc == 3, oc == 4});
    check({req, " R5 syndrome"}, syndrome, (oc == 3 || oc == 4) ? 8'h03 : 8'h00);
    check({req, " R8 rdData"}, rdData, (oc == 1 && !reqWrite) ? mdl[bk] : 32'h0);
    @(posedge clk);
    if (oc == 1 && reqWrite) mdl[bk] = wrData;
    @(negedge clk);
  endtask

  task automatic readBank(input logic b, input string req);
    reqValid = 1; reqWrite = 0; setEnc(1); curLevel = 2'd3; nsBit = b;
    doReq(req);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    nFails++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    mdl[0] = 0; mdl[1] = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R10: both copies read zero after reset
    readBank(0, "R10 bank0");
    readBank(1, "R10 bank1");
    // R7: level-3 writes to each bank
    reqValid = 1; reqWrite = 1; curLevel = 3; nsBit = 0; wrData = 32'hA5A5_0001; doReq("R7 wr bank0");
    nsBit = 1; wrData = 32'h5A5A_0002; doReq("R7 wr bank1");
    readBank(0, "R7 R9 rd bank0");
    readBank(1, "R7 R9 rd bank1");
    // R3: level 0 write is undefined, no change
    reqWrite = 1; curLevel = 0; wrData = 32'hDEAD_BEEF; doReq("R3 undef wr");
    readBank(0, "R3 R9 bank0 kept");
    // R4: trap chain, 64-bit hyp with aux trap, then mismatched bits ignored
    reqWrite = 1; curLevel = 1; hypEnabled = 1; hypIs64 = 1; auxTrap64 = 1;
    wrData = 32'h1111_1111; doReq("R4 trap64");
    auxTrap64 = 0; grpTrap32 = 1; auxTrap32 = 1; monPresent = 1; monIs64 = 0;
    doReq("R4 R6 ignored 32-bit bits");
    readBank(1, "R6 R9 bank1 written");
    curLevel = 1; reqWrite = 0; hypIs64 = 0; doReq("R4 trap32 read");
    hypEnabled = 0; doReq("R4 disabled hyp");
    // R1: unmatched encoding writes nothing
    reqWrite = 1; curLevel = 3; nsBit = 0; setEnc(0); wrData = 32'hFFFF_FFFF; doReq("R1 unmatched");
    readBank(0, "R1 bank0 kept");

    for (int i = 0; i < 2000; i++) begin
      reqValid = $urandom_range(9, 0) != 0;
      reqWrite = $urandom_range(1, 0);
      setEnc($urandom_range(4, 0) != 0);
      wrData = $urandom;
      curLevel = $urandom_range(3, 0);
      hypEnabled = $urandom_range(1, 0); hypIs64 = $urandom_range(1, 0);
      monPresent = $urandom_range(1, 0); monIs64 = $urandom_range(1, 0);
      nsBit = $urandom_range(1, 0);
      grpTrap64 = $urandom_range(3, 0) == 0; grpTrap32 = $urandom_range(3, 0) == 0;
      auxTrap64 = $urandom_range(3, 0) == 0; auxTrap32 = $urandom_range(3, 0) == 0;
      doReq("R1 R2 R4 R6 R7 R8 R9 random");
    end
    readBank(0, "R9 final bank0");
    readBank(1, "R9 final bank1");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule